// File: doc/BRIEF.md
# Timer Tick Source with Prescaler and External Edge Input

This unit feeds a timer counter with a count-enable strobe one system clock wide. A 3-bit select input picks where the strobe comes from. It can be held off. It can fire on every system clock. It can fire once per 8, 64, 256 or 1024 system clocks. It can also fire once per falling or rising edge seen on an asynchronous external pin. The counter that uses the strobe and the register that holds the select code both live outside this unit.

Inside, a 10-bit counter runs freely from reset and provides the divided rates. The external pin passes through a two-flop synchronizer, and one more flop detects its edges. A registered multiplexer then picks the source named by the select code. A change of select code therefore acts on the next clock cycle and cannot create a stray strobe. For scale: at a 16 MHz system clock, divide-by-1024 gives one strobe every 64 µs (15625 Hz), so an 8-bit counter wraps every 16.384 ms.

Top module: `timer_tick_source`

## Requirements
- R1: With select code 000 the tick output stays low.
- R2: With select code 001 the tick output is high in every cycle that follows a sampling clock edge.
- R3: The divider counts clock edges since reset release, with m = 1 at the first edge after release. Select codes 010, 011, 100 and 101 raise the tick after edge m exactly when m is a multiple of 8, 64, 256 or 1024 respectively.
- R4: The divider keeps counting whatever the select code, so after any switch between ratios the ticks stay on the grid of multiples of the new ratio. The grid is counted from reset release.
- R5: With select code 110, the tick after edge m is high exactly when the external input sampled at edge m-3 was high and the value sampled at edge m-2 was low. Each falling edge therefore gives one tick one cycle wide.
- R6: With select code 111, the tick after edge m is high exactly when the external input sampled at edge m-3 was low and the value sampled at edge m-2 was high.
- R7: The tick after edge m is decided only by the select code sampled at that same edge. Changing the code adds no tick outside the pattern of the newly selected source.
- R8: While reset is low the tick output is low, the divider is cleared, and the synchronizer stages are cleared to low. External samples taken before reset release count as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Tick source select code |
| ext_in | input | 1 | Asynchronous external count input |
| tick | output | 1 | Count-enable strobe, one cycle wide |

## Verification
Long directed stretches at divide-by-1024 and divide-by-1 show whether the tick lands on the right multiple of the edge count. They also catch an off-by-one in the tap choice. The external modes are driven with slow toggles and with fast random toggles. These patterns separate falling from rising detection, show the three-cycle synchronizer latency, and show that each edge gives exactly one tick. Random select changes with random hold times test that the divider keeps its phase across switches and that a change never adds a stray tick. A second reset in mid-run tests that the divider and the synchronizer clear again.

// File: rtl/timer_tick_pkg.sv
// Shared types for the timer tick source.
// Assumes the division ratios are powers of two that fit the divider width.
package timer_tick_pkg;

    // Select codes; the numeric values are the externally visible encoding.
    typedef enum logic [2:0] {
        CS_STOP     = 3'b000,
        CS_DIV1     = 3'b001,
        CS_DIV8     = 3'b010,
        CS_DIV64    = 3'b011,
        CS_DIV256   = 3'b100,
        CS_DIV1024  = 3'b101,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } clk_sel_e;

    // Number of divided taps (8, 64, 256, 1024).
    localparam int N_TAPS = 4;

    // log2 of the ratio for tap index i.
    function automatic int tap_shift(input int i);
        case (i)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/prescale_divider.sv
// Free-running binary divider.
// Clears on synchronous active-low reset, then advances once per clock,
// independent of the selected tick source.
module prescale_divider #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DIV_W-1:0] count
);

    // Advance the divider every cycle, wrapping at 2**DIV_W.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    // R3
    // R4
    div_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count == $past(count) + 1'b1);

    // R8
    div_clear_chk: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 && rst_n |-> count == '0);

endmodule

// File: rtl/prescale_taps.sv
// Decodes the divider into one terminal-count flag per ratio.
// Flag i is high while the low tap_shift(i) bits of the count are all ones,
// which makes the registered tick fall on multiples of the ratio.
// Assumes every tap_shift(i) is no larger than DIV_W.
module prescale_taps
    import timer_tick_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic [DIV_W-1:0]  count,
    output logic [N_TAPS-1:0] wrap
);

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int SH = tap_shift(i);
        // Terminal-count decode for this ratio.
        always_comb wrap[i] = &count[SH-1:0];
    end

endmodule

// File: rtl/ext_edge_detect.sv
// Synchronizes an asynchronous pin and flags its edges.
// SYNC_STAGES flops (at least 2) resolve metastability. One more flop holds
// the previous synchronized level, and the rise and fall flags are each one
// cycle wide. Every stage clears to low on reset.
module ext_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Compare current and previous synchronized levels.
    always_comb begin
        rise = sync_q[SYNC_STAGES-1] & ~last_q;
        fall = ~sync_q[SYNC_STAGES-1] & last_q;
    end

    // R5
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

    // R6
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tick_select.sv
// Registered tick source multiplexer.
// Samples the select code and all candidate sources at the same edge, so a
// code change acts on the next cycle and cannot add a stray pulse.
module tick_select
    import timer_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel,
    input  logic [N_TAPS-1:0] wrap,
    input  logic              rise,
    input  logic              fall,
    output logic              tick
);

    logic tick_d;

    // Pick the candidate named by the select code.
    always_comb begin
        case (clk_sel_e'(sel))
            CS_DIV1:     tick_d = 1'b1;
            CS_DIV8:     tick_d = wrap[0];
            CS_DIV64:    tick_d = wrap[1];
            CS_DIV256:   tick_d = wrap[2];
            CS_DIV1024:  tick_d = wrap[3];
            CS_EXT_FALL: tick_d = fall;
            CS_EXT_RISE: tick_d = rise;
            default:     tick_d = 1'b0;
        endcase
    end

    // Register the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= tick_d;
    end

    // R1
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel) == CS_STOP |-> !tick);

    // R2
    div1_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sel) == CS_DIV1 |-> tick);

endmodule

// File: rtl/timer_tick_source.sv
// Top of the timer tick source: divider, tap decode, pin edge detector and
// registered source select. Output is a one-cycle count-enable strobe.
// Assumes clk_sel is synchronous to clk; ext_in may be fully asynchronous.
module timer_tick_source
    import timer_tick_pkg::*;
#(
    parameter int DIV_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       ext_in,
    output logic       tick
);

    localparam int TOP_SH = tap_shift(N_TAPS - 1);

    logic [DIV_W-1:0]  count;
    logic [N_TAPS-1:0] wrap;
    logic              rise;
    logic              fall;

    prescale_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    prescale_taps #(.DIV_W(DIV_W)) u_taps (
        .count (count),
        .wrap  (wrap)
    );

    ext_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_in),
        .rise   (rise),
        .fall   (fall)
    );

    tick_select u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .wrap  (wrap),
        .rise  (rise),
        .fall  (fall),
        .tick  (tick)
    );

    // R3
    div_top_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && $past(clk_sel) == CS_DIV1024 |-> &$past(count[TOP_SH-1:0]));

    // R7
    div8_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && $past(clk_sel) == CS_DIV8 |-> &$past(count[2:0]));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> !tick);

endmodule

// File: tb/timer_tick_source_test.sv
module timer_tick_source_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic       ext_in = 1'b0;
    logic       tick;

    int n_run = 0;
    int n_fail = 0;
    int m = 0;
    logic [2:0] sel_h [0:16383];
    logic       ext_h [0:16383];

    always #2.5 clk = ~clk;

    timer_tick_source uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .ext_in  (ext_in),
        .tick    (tick)
    );

    // Record the inputs seen at each edge since reset release.
    always @(posedge clk) begin
        if (!rst_n) m <= 0;
        else begin
            sel_h[m + 1] <= clk_sel;
            ext_h[m + 1] <= ext_in;
            m <= m + 1;
        end
    end

    function automatic logic ext_at(input int k);
        return (k < 1) ? 1'b0 : ext_h[k];
    endfunction

    // Expected tick after edge k, from the requirements.
    function automatic logic exp_tick(input int k);
        if (k < 1) return 1'b0;
        case (sel_h[k])
            3'b000: return 1'b0;
            3'b001: return 1'b1;
            3'b010: return (k % 8) == 0;
            3'b011: return (k % 64) == 0;
            3'b100: return (k % 256) == 0;
            3'b101: return (k % 1024) == 0;
            3'b110: return ext_at(k - 3) && !ext_at(k - 2);
            default: return !ext_at(k - 3) && ext_at(k - 2);
        endcase
    endfunction

    function automatic string req_of(input int k);
        if (k < 1) return "R8";
        case (sel_h[k])
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010, 3'b011, 3'b100, 3'b101: return "R3/R4/R7";
            3'b110: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at edge %0d: tick=%b expected %b", req, m, act, exp);
        end
    endtask

    // Run n cycles; on each falling edge check tick, then drive new inputs.
    task automatic run(input int n, input int sel, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) check(tick, exp_tick(m), req_of(m));
            else       check(tick, 1'b0, "R8");
            if (sel >= 0) clk_sel = 3'(sel);
            case (mode)
                1: if ((i % 7) == 0) ext_in = ~ext_in;
                2: ext_in = 1'($urandom);
                default: ;
            endcase
        end
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        ext_in = 1'b1;   // R8: high pin during reset must not look like an edge later
        run(n, -1, 0);
        @(negedge clk);
        check(tick, 1'b0, "R8");
        rst_n = 1'b1;
        ext_in = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(4);
        run(2100, 5, 2);        // R3 divide-by-1024 over two wraps
        run(40, 1, 0);          // R2
        run(60, 0, 2);          // R1 with a busy pin
        run(300, 6, 1);         // R5 slow toggles
        run(300, 7, 1);         // R6 slow toggles
        run(300, 6, 2);         // R5 fast toggles
        run(300, 7, 2);         // R6 fast toggles
        run(520, 4, 2);         // R3/R4 divide-by-256 after switch
        for (int s = 0; s < 60; s++)   // R4/R7 random switching
            run(1 + ($urandom % 90), $urandom % 8, 2);
        do_reset(3);            // R8 mid-run reset
        run(10, 1, 0);
        for (int s = 0; s < 30; s++)
            run(1 + ($urandom % 120), $urandom % 8, 2);
        run(1100, 2, 2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule